// File: doc/BRIEF.md
# Up/Down Stepped Pulse-Width Modulator

This block turns one clock into a pulse train whose period never changes and whose high time is set by a small duty register. Two single-bit request inputs move that register. One raises it and the other lowers it. When both are present, the raise wins. The register is updated only on a slow update tick, so a request held for a long time moves the duty one step per tick and never jumps. The duty value stops at its lowest and highest settings instead of wrapping around.

A prescaler inside the block makes two clock enables from the single clock. The fast enable advances a free-running reference counter as wide as the duty register. The slow enable is the update tick for the duty register. Each cycle a comparator tests the reference count against the duty value and registers the result. That result drives the true output, and a separately registered output carries its complement. Because there is only one clock domain, the block can drive an LED or a power stage directly, with the request inputs coming from already-debounced controls.

Top module: `pwm_updown`

## Requirements
- R1: Synchronous active-high reset clears the duty value, the reference counter and the prescaler. During and after reset, `pwm_out` is 0 and `pwm_out_n` is 1 until the duty value is raised.
- R2: On a slow tick with `up_req` = 1 and the duty value below its maximum (all ones, 15 for the default width), the duty value rises by exactly one.
- R3: On a slow tick with `up_req` = 0, `dn_req` = 1 and the duty value above 0, the duty value falls by exactly one.
- R4: On a slow tick with both `up_req` and `dn_req` at 1, the duty value rises by one, as in R2.
- R5: A raise request while the duty value is at its maximum leaves it at the maximum.
- R6: A lower request while the duty value is 0 leaves it at 0.
- R7: The output period is 2^DW fast-enable intervals, which is 2^DW·FAST_DIV clocks. Within each period `pwm_out` is high for duty·FAST_DIV clocks: it is high while the reference count is strictly below the duty value. A duty value of 0 keeps the output low.
- R8: `pwm_out_n` is always the logical complement of `pwm_out`.
- R9: A slow tick with neither request asserted leaves the duty value unchanged.
- R10: The duty value changes only in the cycle after a slow tick. The slow tick fires once every FAST_DIV·SLOW_DIV clocks, so a request held for exactly that many clocks moves the duty value by exactly one step.
- R11: Asserting reset in the middle of operation returns the duty value to 0 and the outputs to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock. Both rates are derived from it. |
| rst | input | 1 | Synchronous reset, active high |
| up_req | input | 1 | Request to raise the duty value on the next slow tick |
| dn_req | input | 1 | Request to lower the duty value on the next slow tick (loses to `up_req`) |
| pwm_out | output | 1 | Pulse-width-modulated output |
| pwm_out_n | output | 1 | Complement of `pwm_out` |

## Verification
The duty register can only be seen as the number of high clocks in one full output period. A wrong step, a missed saturation or a wrong priority therefore shows up as a high count that is off by a multiple of FAST_DIV, within one period after the next slow tick. A corrupted reference counter shows up as a changed period or a wrong high count in the same period. A broken complement register shows up in the very next cycle as `pwm_out_n` equal to `pwm_out`. Because each request is held for exactly one tick interval, a prescaler that fires too often or too rarely shows up as a step of two or zero.

// File: rtl/pwm_updown_pkg.sv
package pwm_updown_pkg;

    // What the duty register does on a slow tick.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_INC  = 2'd1,
        ACT_DEC  = 2'd2
    } step_act_e;

    // The raise request has priority over the lower request.
    function automatic step_act_e pick_action(input logic up, input logic dn);
        if (up)      return ACT_INC;
        else if (dn) return ACT_DEC;
        else         return ACT_HOLD;
    endfunction

endpackage

// File: rtl/pwm_rate_gen.sv
module pwm_rate_gen #(
    parameter int FAST_DIV = 4,
    parameter int SLOW_DIV = 4096
) (
    input  logic clk,
    input  logic rst,
    output logic fast_en,
    output logic slow_tick
);
    localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [SW-1:0] S_LAST = SW'(SLOW_DIV - 1);

    // Fast enable: either every clock or one clock in FAST_DIV.
    generate
        if (FAST_DIV > 1) begin : g_fdiv
            localparam int FW = $clog2(FAST_DIV);
            localparam logic [FW-1:0] F_LAST = FW'(FAST_DIV - 1);

            typedef struct packed {
                logic [FW-1:0] cnt;
            } fast_st_t;

            fast_st_t f_d, f_q;

            always_comb begin
                f_d = f_q;
                f_d.cnt = (f_q.cnt == F_LAST) ? '0 : f_q.cnt + 1'b1;
            end

            always_ff @(posedge clk) begin
                if (rst) f_q <= '0;
                else     f_q <= f_d;
            end

            assign fast_en = (f_q.cnt == F_LAST);
        end else begin : g_nodiv
            assign fast_en = 1'b1;
        end
    endgenerate

    // Slow tick: one fast enable in SLOW_DIV.
    typedef struct packed {
        logic [SW-1:0] cnt;
    } slow_st_t;

    slow_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (fast_en) begin
            s_d.cnt = (s_q.cnt == S_LAST) ? '0 : s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign slow_tick = fast_en && (s_q.cnt == S_LAST);

endmodule

// File: rtl/pwm_duty_reg.sv
module pwm_duty_reg
    import pwm_updown_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          up,
    input  logic          dn,
    output logic [DW-1:0] duty
);
    localparam logic [DW-1:0] D_MAX = '1;

    typedef struct packed {
        logic [DW-1:0] duty;
    } duty_st_t;

    duty_st_t st_d, st_q;
    step_act_e act;

    always_comb begin
        st_d = st_q;
        act  = pick_action(up, dn);
        if (tick) begin
            case (act)
                ACT_INC: if (st_q.duty != D_MAX) st_d.duty = st_q.duty + 1'b1;
                ACT_DEC: if (st_q.duty != '0)    st_d.duty = st_q.duty - 1'b1;
                default: st_d.duty = st_q.duty;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign duty = st_q.duty;

endmodule

// File: rtl/pwm_cmp.sv
module pwm_cmp #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fast_en,
    input  logic [DW-1:0] duty,
    output logic [DW-1:0] ref_cnt,
    output logic          pwm,
    output logic          pwm_n
);
    typedef struct packed {
        logic [DW-1:0] ref_cnt;
        logic          pwm;
        logic          pwm_n;
    } cmp_st_t;

    localparam cmp_st_t CMP_RST = '{ref_cnt: '0, pwm: 1'b0, pwm_n: 1'b1};

    cmp_st_t st_d, st_q;
    logic    below;

    always_comb begin
        st_d  = st_q;
        below = (st_q.ref_cnt < duty);
        if (fast_en) st_d.ref_cnt = st_q.ref_cnt + 1'b1;
        st_d.pwm   = below;
        st_d.pwm_n = !below;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= CMP_RST;
        else     st_q <= st_d;
    end

    assign ref_cnt = st_q.ref_cnt;
    assign pwm     = st_q.pwm;
    assign pwm_n   = st_q.pwm_n;

endmodule

// File: rtl/pwm_updown.sv
module pwm_updown #(
    parameter int DW       = 4,
    parameter int FAST_DIV = 4,
    parameter int SLOW_DIV = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic up_req,
    input  logic dn_req,
    output logic pwm_out,
    output logic pwm_out_n
);
    logic          fast_en_w;
    logic          slow_tick_w;
    logic [DW-1:0] duty_w;
    logic [DW-1:0] ref_w;

    pwm_rate_gen #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_rate (
        .clk       (clk),
        .rst       (rst),
        .fast_en   (fast_en_w),
        .slow_tick (slow_tick_w)
    );

    pwm_duty_reg #(.DW(DW)) u_duty (
        .clk  (clk),
        .rst  (rst),
        .tick (slow_tick_w),
        .up   (up_req),
        .dn   (dn_req),
        .duty (duty_w)
    );

    pwm_cmp #(.DW(DW)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .fast_en (fast_en_w),
        .duty    (duty_w),
        .ref_cnt (ref_w),
        .pwm     (pwm_out),
        .pwm_n   (pwm_out_n)
    );

endmodule

// File: rtl/pwm_updown_chk.sv
module pwm_updown_chk #(
    parameter int DW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          up,
    input logic          dn,
    input logic          fast_en,
    input logic          slow_tick,
    input logic [DW-1:0] duty,
    input logic [DW-1:0] ref_cnt,
    input logic          pwm,
    input logic          pwm_n
);
    localparam logic [DW-1:0] D_MAX = '1;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (duty == '0) && (ref_cnt == '0) && !pwm && pwm_n);

    // R2
    up_step_chk: assert property (@(posedge clk) disable iff (rst)
        (slow_tick && up && !dn && duty != D_MAX) |=> duty == DW'($past(duty) + 1'b1));

    // R3
    down_step_chk: assert property (@(posedge clk) disable iff (rst)
        (slow_tick && !up && dn && duty != '0) |=> duty == DW'($past(duty) - 1'b1));

    // R4
    up_priority_chk: assert property (@(posedge clk) disable iff (rst)
        (slow_tick && up && dn && duty != D_MAX) |=> duty == DW'($past(duty) + 1'b1));

    // R5
    top_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (slow_tick && up && duty == D_MAX) |=> duty == D_MAX);

    // R6
    bottom_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (slow_tick && !up && dn && duty == '0) |=> duty == '0);

    // R7
    ref_advance_chk: assert property (@(posedge clk) disable iff (rst)
        fast_en |=> ref_cnt == DW'($past(ref_cnt) + 1'b1));

    // R7
    ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fast_en |=> $stable(ref_cnt));

    // R7
    compare_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pwm == ($past(ref_cnt) < $past(duty)));

    // R8
    complement_chk: assert property (@(posedge clk) disable iff (rst)
        pwm_n == !pwm);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (slow_tick && !up && !dn) |=> $stable(duty));

    // R10
    tick_only_chk: assert property (@(posedge clk) disable iff (rst)
        !slow_tick |=> $stable(duty));

endmodule

bind pwm_updown pwm_updown_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .up        (up_req),
    .dn        (dn_req),
    .fast_en   (fast_en_w),
    .slow_tick (slow_tick_w),
    .duty      (duty_w),
    .ref_cnt   (ref_w),
    .pwm       (pwm_out),
    .pwm_n     (pwm_out_n)
);

// File: tb/pwm_updown_bench.sv
module pwm_updown_bench;
    localparam int DW       = 4;
    localparam int FAST_DIV = 2;
    localparam int SLOW_DIV = 8;
    localparam int T_TICK   = FAST_DIV * SLOW_DIV;   // clocks between slow ticks
    localparam int P_PWM    = (1 << DW) * FAST_DIV;  // clocks per output period
    localparam int D_MAX    = (1 << DW) - 1;

    // Each entry: {up, dn, expected duty after one tick}
    localparam int NV = 8;
    localparam logic [5:0] VEC [NV] = '{
        {1'b1, 1'b0, 4'd1},
        {1'b1, 1'b0, 4'd2},
        {1'b1, 1'b0, 4'd3},
        {1'b1, 1'b1, 4'd4},
        {1'b0, 1'b1, 4'd3},
        {1'b0, 1'b0, 4'd3},
        {1'b0, 1'b1, 4'd2},
        {1'b1, 1'b1, 4'd3}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic up_req = 1'b0;
    logic dn_req = 1'b0;
    logic pwm_out, pwm_out_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pwm_updown #(.DW(DW), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_pwm_updown (
        .clk       (clk),
        .rst       (rst),
        .up_req    (up_req),
        .dn_req    (dn_req),
        .pwm_out   (pwm_out),
        .pwm_out_n (pwm_out_n)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Hold the requests for exactly one tick interval, then release them and settle.
    task automatic step(input logic u, input logic d);
        @(negedge clk);
        up_req = u;
        dn_req = d;
        repeat (T_TICK) @(posedge clk);
        @(negedge clk);
        up_req = 1'b0;
        dn_req = 1'b0;
        repeat (4) @(posedge clk);
    endtask

    // Count high clocks over one period and clocks where the outputs are not complements.
    task automatic measure(output int highs, output int bad_n);
        highs = 0;
        bad_n = 0;
        repeat (P_PWM) begin
            @(negedge clk);
            if (pwm_out) highs++;
            if (pwm_out_n == pwm_out) bad_n++;
        end
    endtask

    task automatic expect_duty(input string req, input int exp_duty);
        int h, b;
        measure(h, b);
        check(req, h, exp_duty * FAST_DIV);
        check("R8 complement", b, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 pwm in reset", int'(pwm_out), 0);
        check("R1 pwm_n in reset", int'(pwm_out_n), 1);
        rst = 1'b0;
        repeat (4) @(posedge clk);
        expect_duty("R1 R7 zero duty after reset", 0);

        // Vector table: R2 R3 R4 R9 R10
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][5], VEC[i][4]);
            expect_duty($sformatf("R2/R3/R4/R9/R10 vector %0d", i), int'(VEC[i][3:0]));
        end

        // R5: climb to the top, then one more raise
        for (int i = 0; i < D_MAX; i++) step(1'b1, 1'b0);
        expect_duty("R5 R7 at max", D_MAX);
        step(1'b1, 1'b0);
        expect_duty("R5 saturate high", D_MAX);
        step(1'b1, 1'b1);
        expect_duty("R4 R5 both at max", D_MAX);

        // R6: descend to the bottom, then one more lower
        for (int i = 0; i < D_MAX; i++) step(1'b0, 1'b1);
        expect_duty("R6 R7 at zero", 0);
        step(1'b0, 1'b1);
        expect_duty("R6 saturate low", 0);

        // R11: reset in mid-run
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        expect_duty("R2 before mid reset", 2);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R11 pwm in mid reset", int'(pwm_out), 0);
        check("R11 pwm_n in mid reset", int'(pwm_out_n), 1);
        rst = 1'b0;
        repeat (4) @(posedge clk);
        expect_duty("R11 duty cleared", 0);

        finish_run();
    end

endmodule